// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel byte into one asynchronous serial frame. The byte is offered with a valid/ready handshake. A control word, taken at the moment the byte is accepted, fixes the shape of the frame. That shape covers the character length (5 to 8 bits), whether a parity bit is added and of which sense, and how long the stop period lasts.

Bit timing comes from an external enable that pulses at sixteen times the baud rate. The block counts these pulses to time every bit, so it holds no divider of its own. Clock cycles without a pulse leave the frame unchanged. A producer may hold valid high to stream characters back to back. The next start bit then begins in the cycle after the previous stop period ends.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, `txLine` is 1 (mark) and `inReady` is 1.
- R2: A byte is accepted on a rising clock edge where `inValid` and `inReady` are both 1. `inReady` is 0 from the cycle after that edge until the stop period ends. It is 1 again in the cycle right after the last stop tick is consumed, so a waiting byte is accepted in the next cycle.
- R3: The frame opens with a start bit of 0. It lasts 16 `baudTick` pulses, and counting begins with the first pulse after the accepting edge.
- R4: `lineCfg[1:0]` sets the character length: codes 00, 01, 10 and 11 give 5, 6, 7 and 8 data bits. The data bits follow the start bit with the least significant bit first. Byte bits above the chosen length are never sent.
- R5: With `lineCfg[3]` = 1, one parity bit follows the last data bit. With `lineCfg[4]` = 1 the parity is even, so the bit is the XOR of the sent data bits. With `lineCfg[4]` = 0 the parity is odd, so the bit is the complement of that XOR. With `lineCfg[3]` = 0 no parity bit is sent.
- R6: The stop period is 1 on the line. It lasts 16 ticks when `lineCfg[2]` = 0. It lasts 24 ticks when `lineCfg[2]` = 1 with 5-bit characters, and 32 ticks when `lineCfg[2]` = 1 with 6, 7 or 8-bit characters.
- R7: `lineCfg` is sampled only when a byte is accepted. Changes during a frame do not affect that frame.
- R8: While `inValid` is 0, no frame starts: `txLine` stays 1 and `inReady` stays 1.
- R9: Each whole bit lasts exactly 16 `baudTick` pulses, and the half stop segment lasts 8. Clock cycles without a pulse do not advance the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inByte | input | 8 | Byte to send |
| inValid | input | 1 | Byte offered |
| inReady | output | 1 | Block can accept a byte |
| baudTick | input | 1 | Enable at 16x the baud rate |
| lineCfg | input | 5 | Frame control: [1:0] length, [2] long stop, [3] parity on, [4] even parity |
| txLine | output | 1 | Serial output, idles high |

## Verification
Two events can land on the same clock edge. One is the consumption of the final stop tick. The other is the acceptance of the next byte, which may arrive together with a baud pulse that must not count toward the new start bit. The bench provokes this by holding valid high across consecutive sends and by running the tick enable on every clock as well as on every third clock. A scoreboard counts the ticks after each falling start edge. It requires `inReady` to be low on the final stop tick and high on the cycle that follows. It also requires the start bit sampled at tick 8 to be low and every later bit to land at its 16-tick position.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int CFG_W        = 5;
  localparam int CFG_LEN_LSB  = 0;
  localparam int CFG_LONG_STP = 2;
  localparam int CFG_PAR_ON   = 3;
  localparam int CFG_PAR_EVEN = 4;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_PARITY,
    TX_STOP,
    TX_STOP_EXTRA
  } txState_e;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_PARITY
  } lineSel_e;

  typedef struct packed {
    logic     load;
    logic     emit;
    lineSel_e lineSel;
  } txStrobe_t;

endpackage

// File: rtl/async_tx_datapath.sv
module async_tx_datapath
  import async_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MIN_BITS = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  txStrobe_t                  strobe,
  input  logic [DATA_W-1:0]          inByte,
  input  logic [CFG_W-1:0]           lineCfg,
  output logic                       txLine,
  output logic [$clog2(DATA_W)-1:0]  lastBitIdx,
  output logic                       parityEn,
  output logic                       stopExtra,
  output logic                       stopHalf
);

  localparam int BIT_IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0]    shiftQ;
  logic                 parityQ;
  logic [CFG_W-1:0]     cfgQ;
  logic                 lineQ;

  logic [BIT_IDX_W-1:0] inLastIdx;
  logic [DATA_W-1:0]    keepMask;
  logic [DATA_W-1:0]    maskedByte;
  logic                 parityNext;

  assign inLastIdx = BIT_IDX_W'(MIN_BITS - 1)
                   + BIT_IDX_W'(lineCfg[CFG_LEN_LSB+1:CFG_LEN_LSB]);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign keepMask[i] = (BIT_IDX_W'(i) <= inLastIdx);
  end

  assign maskedByte = inByte & keepMask;
  assign parityNext = (^maskedByte) ^ ~lineCfg[CFG_PAR_EVEN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      parityQ <= 1'b0;
      cfgQ    <= '0;
      lineQ   <= 1'b1;
    end else if (strobe.load) begin
      shiftQ  <= maskedByte;
      parityQ <= parityNext;
      cfgQ    <= lineCfg;
      lineQ   <= 1'b0;
    end else if (strobe.emit) begin
      unique case (strobe.lineSel)
        LINE_MARK:   lineQ <= 1'b1;
        LINE_SPACE:  lineQ <= 1'b0;
        LINE_DATA: begin
          lineQ  <= shiftQ[0];
          shiftQ <= shiftQ >> 1;
        end
        LINE_PARITY: lineQ <= parityQ;
      endcase
    end
  end

  assign txLine     = lineQ;
  assign lastBitIdx = BIT_IDX_W'(MIN_BITS - 1)
                    + BIT_IDX_W'(cfgQ[CFG_LEN_LSB+1:CFG_LEN_LSB]);
  assign parityEn   = cfgQ[CFG_PAR_ON];
  assign stopExtra  = cfgQ[CFG_LONG_STP];
  assign stopHalf   = cfgQ[CFG_LONG_STP]
                    && (cfgQ[CFG_LEN_LSB+1:CFG_LEN_LSB] == 2'b00);

  // R5: a parity slot is only requested when the latched control enables it
  p_parity_only_when_on_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && strobe.lineSel == LINE_PARITY) |-> parityEn);

  // R3: loading a byte drives the start level on the following cycle
  p_space_after_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !txLine);

  // R7: latched control stays put unless a new byte is loaded
  p_cfg_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(cfgQ));

endmodule

// File: rtl/async_tx_ctrl.sv
module async_tx_ctrl
  import async_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic                       baudTick,
  input  logic [$clog2(DATA_W)-1:0]  lastBitIdx,
  input  logic                       parityEn,
  input  logic                       stopExtra,
  input  logic                       stopHalf,
  output logic                       inReady,
  output txStrobe_t                  strobe
);

  localparam int CNT_W     = $clog2(TICKS_PER_BIT);
  localparam int HALF      = TICKS_PER_BIT / 2;
  localparam int BIT_IDX_W = $clog2(DATA_W);

  txState_e             state, stateNext;
  logic [CNT_W-1:0]     tickCnt;
  logic [CNT_W-1:0]     tickLimit;
  logic [BIT_IDX_W-1:0] bitCnt, bitNext;
  logic                 periodDone;

  assign tickLimit  = (state == TX_STOP_EXTRA && stopHalf)
                    ? CNT_W'(HALF - 1) : CNT_W'(TICKS_PER_BIT - 1);
  assign periodDone = baudTick && (state != TX_IDLE) && (tickCnt == tickLimit);

  always_comb begin
    stateNext      = state;
    bitNext        = bitCnt;
    strobe         = '0;
    strobe.lineSel = LINE_MARK;
    unique case (state)
      TX_IDLE: begin
        if (inValid) begin
          stateNext   = TX_START;
          strobe.load = 1'b1;
        end
      end
      TX_START: begin
        if (periodDone) begin
          stateNext      = TX_DATA;
          bitNext        = '0;
          strobe.emit    = 1'b1;
          strobe.lineSel = LINE_DATA;
        end
      end
      TX_DATA: begin
        if (periodDone) begin
          strobe.emit = 1'b1;
          if (bitCnt == lastBitIdx) begin
            if (parityEn) begin
              stateNext      = TX_PARITY;
              strobe.lineSel = LINE_PARITY;
            end else begin
              stateNext      = TX_STOP;
              strobe.lineSel = LINE_MARK;
            end
          end else begin
            bitNext        = bitCnt + BIT_IDX_W'(1);
            strobe.lineSel = LINE_DATA;
          end
        end
      end
      TX_PARITY: begin
        if (periodDone) begin
          stateNext      = TX_STOP;
          strobe.emit    = 1'b1;
          strobe.lineSel = LINE_MARK;
        end
      end
      TX_STOP: begin
        if (periodDone) begin
          stateNext      = stopExtra ? TX_STOP_EXTRA : TX_IDLE;
          strobe.emit    = 1'b1;
          strobe.lineSel = LINE_MARK;
        end
      end
      TX_STOP_EXTRA: begin
        if (periodDone) begin
          stateNext      = TX_IDLE;
          strobe.emit    = 1'b1;
          strobe.lineSel = LINE_MARK;
        end
      end
      default: stateNext = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= TX_IDLE;
      bitCnt  <= '0;
      tickCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitNext;
      if (state == TX_IDLE) begin
        tickCnt <= '0;
      end else if (baudTick) begin
        tickCnt <= periodDone ? '0 : tickCnt + CNT_W'(1);
      end
    end
  end

  assign inReady = (state == TX_IDLE);

  // R9: without a baud pulse a busy frame does not move
  p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state != TX_IDLE && !baudTick) |=> ($stable(tickCnt) && $stable(state)));

  // R6: the half stop segment never counts past its 8-tick window
  p_half_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == TX_STOP_EXTRA && stopHalf) |-> (tickCnt < CNT_W'(HALF)));

  // R4: the data index stays inside the configured character length
  p_bit_index_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == TX_DATA) |-> (bitCnt <= lastBitIdx));

  // R2: an accepted byte makes the block busy on the next cycle
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import async_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8,
  parameter int MIN_BITS      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inByte,
  input  logic              inValid,
  output logic              inReady,
  input  logic              baudTick,
  input  logic [CFG_W-1:0]  lineCfg,
  output logic              txLine
);

  localparam int BIT_IDX_W = $clog2(DATA_W);

  txStrobe_t            strobe;
  logic [BIT_IDX_W-1:0] lastBitIdx;
  logic                 parityEn;
  logic                 stopExtra;
  logic                 stopHalf;

  async_tx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .DATA_W       (DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .baudTick  (baudTick),
    .lastBitIdx(lastBitIdx),
    .parityEn  (parityEn),
    .stopExtra (stopExtra),
    .stopHalf  (stopHalf),
    .inReady   (inReady),
    .strobe    (strobe)
  );

  async_tx_datapath #(
    .DATA_W  (DATA_W),
    .MIN_BITS(MIN_BITS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inByte    (inByte),
    .lineCfg   (lineCfg),
    .txLine    (txLine),
    .lastBitIdx(lastBitIdx),
    .parityEn  (parityEn),
    .stopExtra (stopExtra),
    .stopHalf  (stopHalf)
  );

  // R8: whenever the block is ready the line rests at mark
  p_mark_when_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> txLine);

  // R8: no offer while idle keeps the block idle at mark
  p_stay_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> (inReady && txLine));

  // R3: acceptance pulls the line to space on the next cycle
  p_start_after_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid) |=> !txLine);

endmodule

// File: tb/async_frame_tx_bench.sv
`timescale 1ns/1ps
module async_frame_tx_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inByte = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic       baudTick = 1'b0;
  logic [4:0] lineCfg = '0;
  logic       txLine;

  int nChecks = 0;
  int nFails  = 0;
  int tickPer = 1;
  int tickPhase = 0;

  always #2.5 clk = ~clk;

  async_frame_tx u_async_frame_tx (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid),
    .inReady(inReady), .baudTick(baudTick), .lineCfg(lineCfg), .txLine(txLine)
  );

  always @(posedge clk) begin
    if (tickPhase >= tickPer - 1) begin
      tickPhase <= 0;
      baudTick  <= 1'b1;
    end else begin
      tickPhase <= tickPhase + 1;
      baudTick  <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // scoreboard queue: {scrambled, cfg, data}
  logic [13:0] expQ[$];

  task automatic send(input logic [7:0] d, input logic [4:0] c, input bit scr);
    inByte  = d;
    lineCfg = c;
    inValid = 1'b1;
    while (inReady !== 1'b1) @(negedge clk);
    expQ.push_back({scr, c, d});
    @(negedge clk);
    if (scr) lineCfg = ~c;
  endtask

  // monitor state
  bit         inFrame = 0;
  bit         endPending = 0;
  int         k, nBits, total, len, stopT;
  bit         par, even, curScr, curSlow, frameErr, busyErr, stopErr;
  logic [7:0] curData;
  logic [13:0] item;

  always @(negedge clk) begin
    if (rstN) begin
      if (endPending) begin
        check(inReady === 1'b1, "R2 ready back after stop", int'(inReady), 1);
        check(!busyErr, "R2 ready low during frame", int'(busyErr), 0);
        if (curScr)  check(!frameErr, "R7 frame kept latched control", int'(frameErr), 0);
        if (curSlow) check(!frameErr, "R9 sparse ticks frame timing", int'(frameErr), 0);
        endPending = 0;
        inFrame    = 0;
      end else if (!inFrame && txLine === 1'b0) begin
        if (expQ.size() == 0) begin
          check(0, "R2 frame without accepted byte", 0, 1);
          item = '0;
        end else begin
          item = expQ.pop_front();
        end
        curScr  = item[13];
        curData = item[7:0];
        len     = 5 + int'(item[9:8]);
        par     = item[11];
        even    = item[12];
        stopT   = item[10] ? ((len == 5) ? 24 : 32) : 16;
        nBits   = 1 + len + int'(par);
        total   = 16 * nBits + stopT;
        curSlow = (tickPer > 1);
        k = 0; frameErr = 0; busyErr = 0; stopErr = 0;
        inFrame = 1;
      end
      if (inFrame && !endPending) begin
        if (inReady !== 1'b0) busyErr = 1;
        if (baudTick) begin
          k++;
          if ((k % 16) == 8 && (k / 16) < nBits) begin
            int idx;
            logic expBit;
            idx = k / 16;
            if (idx == 0) begin
              expBit = 1'b0;
              check(txLine === expBit, "R3 start bit", int'(txLine), int'(expBit));
            end else if (idx <= len) begin
              expBit = curData[idx-1];
              check(txLine === expBit, "R4 data bit", int'(txLine), int'(expBit));
            end else begin
              logic [7:0] m;
              m = curData & 8'((1 << len) - 1);
              expBit = even ? (^m) : ~(^m);
              check(txLine === expBit, "R5 parity bit", int'(txLine), int'(expBit));
            end
            if (txLine !== expBit) frameErr = 1;
          end
          if (k > 16 * nBits && txLine !== 1'b1) stopErr = 1;
          if (k == total) begin
            check(inReady === 1'b0 && !stopErr, "R6 stop length and level",
                  int'(inReady) + 2 * int'(stopErr), 0);
            if (inReady !== 1'b0 || stopErr) frameErr = 1;
            endPending = 1;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    bit idleOk;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(txLine === 1'b1, "R1 line after reset", int'(txLine), 1);
    check(inReady === 1'b1, "R1 ready after reset", int'(inReady), 1);

    // R8: nothing offered, nothing sent
    idleOk = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txLine !== 1'b1 || inReady !== 1'b1) idleOk = 0;
    end
    check(idleOk, "R8 idle without valid", int'(idleOk), 1);

    // dense ticks, back-to-back frames
    tickPer = 1;
    send(8'hF5, 5'b00000, 0);
    send(8'h2C, 5'b00101, 0);
    send(8'hA7, 5'b11010, 0);
    send(8'h3C, 5'b01111, 0);
    send(8'hFF, 5'b11100, 0);
    send(8'h00, 5'b01000, 0);
    inValid = 1'b0;
    while (expQ.size() != 0 || inFrame) @(negedge clk);
    repeat (5) @(negedge clk);

    // sparse ticks, control scrambled mid-frame
    tickPer = 3;
    repeat (4) @(negedge clk);
    send(8'h96, 5'b00111, 1);
    send(8'h4B, 5'b10100, 1);
    send(8'hE1, 5'b11011, 1);
    inValid = 1'b0;
    while (expQ.size() != 0 || inFrame) @(negedge clk);
    repeat (5) @(negedge clk);
    check(txLine === 1'b1 && inReady === 1'b1, "R8 idle after drain",
          int'(txLine) + int'(inReady), 2);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule